// File: doc/BRIEF.md
# Inter-Word Null Gap Timer

This block sits beside the bit validator of a two-wire avionics serial receiver and decides when the line has rested long enough between words for the next reception to be accepted. Once the validator flags the final data bit of a good word, the timer starts. At a fixed interval it looks at the 10-bit history of Null samples. The interval is 10 clocks at the fast line rate and 80 clocks at the slow one.

Each inspection that sees an adequate Null run in both the older and the newer half of that history adds one to a gap count. An inspection that does not see such a run returns the count to zero. When three qualified inspections in a row have been counted, the receive-enable flag rises. It stays high until the first valid bit of the next word arrives. After reset the timer behaves as if a word had just finished, so a full gap is needed before the first word is accepted.

Top module: `word_gap_timer`

## Requirements
- R1: An inspection counts as a qualified Null only when bits 9..5 of `nullHist` (oldest samples) hold three or more adjacent ones and bits 4..0 (newest samples) also hold three or more adjacent ones.
- R2: With `speedLow` = 0, the first inspection happens on the 10th rising edge after the edge that samples `wordEnd` high. Later inspections follow every 10 edges.
- R3: With `speedLow` = 1, the inspection period is 80 edges.
- R4: Each qualified inspection adds one to the gap count. `rxEnable` rises right after the inspection that brings the count to 3, which is edge 3×period after `wordEnd`.
- R5: An inspection that does not find a qualified Null sets the gap count back to zero, so three new qualified inspections are needed.
- R6: After `rxEnable` rises, it stays high whatever `nullHist` does, until `bitStart` or `wordEnd` is seen. The count never goes above 3.
- R7: When `bitStart` is sampled high without `wordEnd`, `rxEnable` is low after that edge. The timer then stays stopped until the next `wordEnd`.
- R8: When `wordEnd` is sampled high, the count and the interval timer are cleared, `rxEnable` is low after that edge, and timing starts again. `wordEnd` wins over a `bitStart` in the same cycle.
- R9: During reset `rxEnable` is low. After reset is released the timer runs as if `wordEnd` had been sampled on the release, so `rxEnable` rises after the 3×period-th edge when the Nulls qualify.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| speedLow | input | 1 | 1 selects the slow line rate (80-clock inspection period); 0 selects 10 clocks |
| wordEnd | input | 1 | One-cycle strobe sent after the last data bit of a valid word |
| bitStart | input | 1 | One-cycle strobe sent when the first valid bit of a word is detected |
| nullHist | input | 10 | Null sampling history from the bit validator; bit 0 is the newest sample |
| rxEnable | output | 1 | High when the receiver may accept the next word |

## Verification
On every cycle, the assertions check the following:
- the gap count stays within its bound;
- the count only steps up by one or falls to zero;
- a failed inspection always clears the count;
- a `wordEnd` or `bitStart` strobe always pulls the enable low on the next edge;
- an idle timer never raises it.

Some behaviour only the bench scenarios can show. These scenarios cover:
- the exact edge on which the enable rises for each speed;
- that a failed inspection in the middle of a gap pushes the unlock back by a full three periods;
- that the enable stays high while Nulls come and go;
- the result of the qualification rule over all 1024 history patterns.

// File: rtl/wgt_pkg.sv
package wgt_pkg;

  // Strobes from the sequencing control to the timing datapath
  typedef struct packed {
    logic clear;  // zero the interval divider and the gap count
    logic run;    // advance the interval divider this cycle
  } gapCtrl_t;

endpackage

// File: rtl/wgt_null_qual.sv
module wgt_null_qual #(
  parameter int HIST_W  = 10,
  parameter int RUN_LEN = 3
) (
  input  logic [HIST_W-1:0] nullHist,
  output logic              qualOk
);
  localparam int HALF = HIST_W / 2;
  localparam int WIN  = HALF - RUN_LEN + 1;

  logic [WIN-1:0] newHit;
  logic [WIN-1:0] oldHit;

  for (genvar w = 0; w < WIN; w++) begin : g_win
    assign newHit[w] = &nullHist[w +: RUN_LEN];
    assign oldHit[w] = &nullHist[HALF + w +: RUN_LEN];
  end

  assign qualOk = (|newHit) && (|oldHit);

  // R1: a qualified history carries at least two full runs of ones
  always_comb begin
    if (qualOk) begin
      a_r1_enough_ones: assert ($countones(nullHist) >= 2 * RUN_LEN);
    end
  end

endmodule

// File: rtl/wgt_gap_dp.sv
module wgt_gap_dp
  import wgt_pkg::*;
#(
  parameter int FAST_DIV  = 10,
  parameter int SLOW_DIV  = 80,
  parameter int GAP_COUNT = 3
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     speedLow,
  input  logic     qualOk,
  input  gapCtrl_t ctl,
  output logic     countFull
);
  localparam int DIV_W = $clog2(SLOW_DIV + 1);
  localparam int CNT_W = $clog2(GAP_COUNT + 1);
  localparam logic [DIV_W-1:0] FAST_LAST = DIV_W'(FAST_DIV - 1);
  localparam logic [DIV_W-1:0] SLOW_LAST = DIV_W'(SLOW_DIV - 1);
  localparam logic [CNT_W-1:0] CNT_TOP   = CNT_W'(GAP_COUNT);

  logic [DIV_W-1:0] divCnt;
  logic [CNT_W-1:0] gapCnt;
  logic [DIV_W-1:0] periodLast;
  logic             inspectNow;

  assign periodLast = speedLow ? SLOW_LAST : FAST_LAST;
  assign inspectNow = ctl.run && (divCnt >= periodLast);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      divCnt <= '0;
    end else if (ctl.clear) begin
      divCnt <= '0;
    end else if (ctl.run) begin
      if (inspectNow) divCnt <= '0;
      else            divCnt <= divCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gapCnt <= '0;
    end else if (ctl.clear) begin
      gapCnt <= '0;
    end else if (inspectNow) begin
      if (!qualOk)                gapCnt <= '0;
      else if (gapCnt != CNT_TOP) gapCnt <= gapCnt + 1'b1;
    end
  end

  assign countFull = (gapCnt == CNT_TOP);

  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    gapCnt <= CNT_TOP);

  a_r2_div_bound: assert property (@(posedge clk) disable iff (!rst_n)
    divCnt <= SLOW_LAST);

  a_r4_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.clear |=> (gapCnt == '0) || (gapCnt == $past(gapCnt)) || (gapCnt == $past(gapCnt) + 1'b1));

  a_r5_bad_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.clear && inspectNow && !qualOk) |=> (gapCnt == '0));

endmodule

// File: rtl/wgt_gap_ctrl.sv
module wgt_gap_ctrl
  import wgt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wordEnd,
  input  logic     bitStart,
  input  logic     countFull,
  output gapCtrl_t ctl
);
  logic armed;

  // Reset arms the timer as though a word has just ended
  always_ff @(posedge clk) begin
    if (!rst_n)        armed <= 1'b1;
    else if (wordEnd)  armed <= 1'b1;
    else if (bitStart) armed <= 1'b0;
  end

  always_comb begin
    ctl.clear = wordEnd || bitStart;
    ctl.run   = armed && !countFull;
  end

  a_r7_start_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (bitStart && !wordEnd) |=> !countFull);

  a_r8_end_closes: assert property (@(posedge clk) disable iff (!rst_n)
    wordEnd |=> !countFull);

  a_r7_idle_stays_shut: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !wordEnd) |=> !countFull);

endmodule

// File: rtl/word_gap_timer.sv
module word_gap_timer
  import wgt_pkg::*;
#(
  parameter int HIST_W    = 10,
  parameter int RUN_LEN   = 3,
  parameter int FAST_DIV  = 10,
  parameter int SLOW_DIV  = 80,
  parameter int GAP_COUNT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              speedLow,
  input  logic              wordEnd,
  input  logic              bitStart,
  input  logic [HIST_W-1:0] nullHist,
  output logic              rxEnable
);
  gapCtrl_t ctl;
  logic     qualOk;
  logic     countFull;

  wgt_null_qual #(.HIST_W(HIST_W), .RUN_LEN(RUN_LEN)) i_qual (
    .nullHist (nullHist),
    .qualOk   (qualOk)
  );

  wgt_gap_ctrl i_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wordEnd   (wordEnd),
    .bitStart  (bitStart),
    .countFull (countFull),
    .ctl       (ctl)
  );

  wgt_gap_dp #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV), .GAP_COUNT(GAP_COUNT)) i_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .speedLow  (speedLow),
    .qualOk    (qualOk),
    .ctl       (ctl),
    .countFull (countFull)
  );

  assign rxEnable = countFull;

endmodule

// File: tb/test_word_gap_timer.sv
`timescale 1ns/1ps
module test_word_gap_timer;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       speedLow;
  logic       wordEnd;
  logic       bitStart;
  logic [9:0] nullHist;
  logic       rxEnable;
  int         checks = 0;
  int         errors = 0;

  always #2 clk = ~clk;

  word_gap_timer i_word_gap_timer (
    .clk(clk), .rst_n(rst_n), .speedLow(speedLow), .wordEnd(wordEnd),
    .bitStart(bitStart), .nullHist(nullHist), .rxEnable(rxEnable)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: rxEnable=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic startGap();
    wordEnd = 1'b1;
    edges(1);
    wordEnd = 1'b0;
  endtask

  // Longest run of ones in each half must reach three
  function automatic logic expQual(input logic [9:0] p);
    int bestLo = 0, bestHi = 0, run;
    run = 0;
    for (int i = 0; i < 5; i++) begin
      run = p[i] ? run + 1 : 0;
      if (run > bestLo) bestLo = run;
    end
    run = 0;
    for (int i = 5; i < 10; i++) begin
      run = p[i] ? run + 1 : 0;
      if (run > bestHi) bestHi = run;
    end
    return (bestLo >= 3) && (bestHi >= 3);
  endfunction

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; speedLow = 1'b0; wordEnd = 1'b0; bitStart = 1'b0; nullHist = 10'h3FF;
    edges(3);
    chk("R9 in reset", rxEnable, 1'b0);
    rst_n = 1'b1;
    edges(29);
    chk("R9 before 30th edge", rxEnable, 1'b0);
    edges(1);
    chk("R9 at 30th edge", rxEnable, 1'b1);

    // R7: first bit closes the gap and halts timing
    bitStart = 1'b1;
    edges(1);
    bitStart = 1'b0;
    chk("R7 close", rxEnable, 1'b0);
    edges(200);
    chk("R7 stays shut", rxEnable, 1'b0);

    // R2/R4: fast period
    startGap();
    chk("R8 cleared on wordEnd", rxEnable, 1'b0);
    edges(29);
    chk("R2 before 30th edge", rxEnable, 1'b0);
    edges(1);
    chk("R4 opens at 30th edge", rxEnable, 1'b1);

    // R6: held open regardless of Nulls
    nullHist = 10'h000;
    edges(100);
    chk("R6 held open", rxEnable, 1'b1);

    // R8: wordEnd while open; R3 slow period
    nullHist = 10'h3FF;
    speedLow = 1'b1;
    startGap();
    chk("R8 close when open", rxEnable, 1'b0);
    edges(239);
    chk("R3 before 240th edge", rxEnable, 1'b0);
    edges(1);
    chk("R3 opens at 240th edge", rxEnable, 1'b1);

    // R5: a failed third inspection restarts the count
    speedLow = 1'b0;
    startGap();
    edges(20);
    nullHist = 10'h000;
    edges(10);
    nullHist = 10'h3FF;
    edges(29);
    chk("R5 before 60th edge", rxEnable, 1'b0);
    edges(1);
    chk("R5 opens at 60th edge", rxEnable, 1'b1);

    // R8: wordEnd has priority over bitStart
    wordEnd = 1'b1; bitStart = 1'b1;
    edges(1);
    wordEnd = 1'b0; bitStart = 1'b0;
    chk("R8 both strobes close", rxEnable, 1'b0);
    edges(29);
    chk("R8 before 30th edge", rxEnable, 1'b0);
    edges(1);
    chk("R8 timer ran", rxEnable, 1'b1);

    // R1: every history pattern
    for (int p = 0; p < 1024; p++) begin
      nullHist = 10'(p);
      startGap();
      edges(30);
      chk("R1 pattern sweep", rxEnable, expQual(10'(p)));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  end
endmodule